// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block takes 35 level-sensitive peripheral request lines and one non-maskable request line. It decides which request goes to the processor and whether that request may interrupt the handler that is running now. Each peripheral line has its own enable and a 5-bit priority, where a smaller value is more urgent. A 3-bit grouping value sets a split point inside every priority. The bits above the split form the group, and only the group can interrupt a running handler. The bits below the split form the sub-priority, which only orders requests that are waiting. Because the group sits in the upper bits, ordering by group and then sub-priority gives the same result as ordering by the whole 5-bit value. The split therefore matters only for the preemption decision.

The block keeps one pending bit and one active bit per line. A request becomes pending when its line is high while the line is enabled. The processor accepts the presented request with `take_ack`, which turns the pending bit into an active bit. It ends the innermost handler with `handler_done`. A small state machine follows the processor context, using three states:
- `ST_IDLE`: no handler is running.
- `ST_HANDLER`: at least one peripheral handler is active.
- `ST_NMI`: the non-maskable handler is running.

The transitions are:
- IDLE→HANDLER: a peripheral request is accepted.
- IDLE→NMI or HANDLER→NMI: the non-maskable request is accepted.
- HANDLER→HANDLER: a nested accept, or retiring an inner handler while others remain.
- HANDLER→IDLE: the last peripheral handler is retired.
- NMI→HANDLER or NMI→IDLE: the non-maskable handler ends, and the next state depends on whether peripheral handlers are still active.

Configuration uses one write port with a select and write data. Select values 0 to 34 address a line: bit 5 is the enable and bits 4:0 are the priority. The all-ones select writes the grouping value from bits 2:0.

Top module: `gpa_arbiter`

## Requirements
- R1: After reset, no request is pending or active, the state is idle, and `win_valid`, `take_req` and `preempt` are 0. In the idle state `preempt` is always 0.
- R2: A configuration write takes effect at the clock edge that samples it. The outputs in the following cycle reflect the new priority, enable or grouping value.
- R3: A line's pending bit is set at a clock edge where the line is high and enabled. A high line that is disabled sets nothing. A pending bit is kept while its line is disabled, hidden from selection, and presented again once the line is re-enabled.
- R4: Among the enabled pending lines, the winner is the one with the smallest 5-bit priority value, and ties go to the lowest line index. `win_vector` is 16 plus the line index.
- R5: In `ST_IDLE` with a winner present, `take_req` is 1. An accept (`take_ack` while `take_req` is 1) clears that line's pending bit and marks it active.
- R6: With a handler active, `preempt` and `take_req` are 1 only if the winner's group is strictly smaller than the group of the most urgent active handler. The group is the priority with its low S bits cleared, where S = grouping−2 for grouping values 2 to 7. Grouping values 0 and 1 act as 2 (S = 0).
- R7: A waiting request whose group is not below the active group is not taken. It is presented with `take_req` set and `preempt` clear once the handlers above it have ended (back-to-back chaining).
- R8: A rising edge on `nmi_i` makes the non-maskable request pending, independent of all enables. It wins over every peripheral request with vector 2 and preempts any peripheral handler. While it is being handled (`ST_NMI`), `take_req` stays 0.
- R9: `handler_done` retires the most urgent running context: the non-maskable handler if it is running, otherwise the active line with the smallest priority. Preemption is then judged against the next context.
- R10: A `take_ack` while `take_req` is 0 changes nothing. The state stays unchanged in any cycle with neither `take_ack` nor `handler_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 35 | Peripheral request lines, level-sensitive |
| nmi_i | input | 1 | Non-maskable request, edge-detected |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 6 | Line index 0–34, or all ones for the grouping value |
| cfg_wdata | input | 6 | Line: {enable, priority[4:0]}; grouping: bits 2:0 |
| take_ack | input | 1 | Processor accepts the presented request |
| handler_done | input | 1 | Processor leaves the innermost handler |
| win_valid | output | 1 | A selectable request exists |
| win_vector | output | 8 | Exception number of the winner (2 or 16+line) |
| take_req | output | 1 | Winner may be taken now |
| preempt | output | 1 | Winner interrupts a running handler |

## Verification
The assertions assume that the processor side is well behaved:
- `take_ack` and `handler_done` never arrive in the same cycle.
- `handler_done` is only given while a handler runs.
- A rising edge on `nmi_i` never coincides with the accept of a pending non-maskable request.

The directed stimulus respects these rules: it drives each handshake as a single-cycle pulse in its own task, and it always ends handlers before a scenario finishes. The stimulus never rewrites the priority of a line whose handler is active, so the nesting order that the retire logic relies on stays consistent.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
    localparam int PRIO_W = 5;
    localparam int GRP_W  = 3;
    localparam int CFG_W  = PRIO_W + 1;
    localparam int EN_BIT = PRIO_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HANDLER = 2'd1,
        ST_NMI     = 2'd2
    } gpa_state_e;

    // Mask keeping only the group part of a priority for a grouping value.
    function automatic logic [PRIO_W-1:0] grp_mask(input logic [GRP_W-1:0] g);
        logic [GRP_W-1:0] sub;
        sub = (g < GRP_W'(2)) ? '0 : g - GRP_W'(2);
        return {PRIO_W{1'b1}} << sub;
    endfunction
endpackage

// File: rtl/gpa_cfg_regs.sv
module gpa_cfg_regs
    import gpa_pkg::*;
#(
    parameter int N_IRQ = 35,
    parameter int SEL_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic [N_IRQ*PRIO_W-1:0] prio_flat,
    output logic [N_IRQ-1:0]        en,
    output logic [GRP_W-1:0]        grouping
);
    localparam logic [SEL_W-1:0] GRP_SEL = {SEL_W{1'b1}};

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        logic [PRIO_W-1:0] prio_q;
        logic              en_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q <= '0;
                en_q   <= 1'b0;
            end else if (cfg_we && cfg_sel == SEL_W'(g)) begin
                prio_q <= cfg_wdata[PRIO_W-1:0];
                en_q   <= cfg_wdata[EN_BIT];
            end
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
        assign en[g] = en_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grouping <= '0;
        end else if (cfg_we && cfg_sel == GRP_SEL) begin
            grouping <= cfg_wdata[GRP_W-1:0];
        end
    end
endmodule

// File: rtl/gpa_pick.sv
module gpa_pick #(
    parameter int N     = 35,
    parameter int W     = 5,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]   vld,
    input  logic [N*W-1:0] key_flat,
    output logic           any,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]   key_min
);
    // Linear scan: strict compare keeps the lowest index on equal keys.
    always_comb begin
        any     = 1'b0;
        idx     = '0;
        key_min = '1;
        for (int i = 0; i < N; i++) begin
            if (vld[i] && (!any || key_flat[i*W +: W] < key_min)) begin
                any     = 1'b1;
                idx     = IDX_W'(i);
                key_min = key_flat[i*W +: W];
            end
        end
    end
endmodule

// File: rtl/gpa_arbiter.sv
module gpa_arbiter
    import gpa_pkg::*;
#(
    parameter int N_IRQ    = 35,
    parameter int SEL_W    = 6,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 16,
    parameter int NMI_VEC  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IRQ-1:0]   irq_i,
    input  logic               nmi_i,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               take_ack,
    input  logic               handler_done,
    output logic               win_valid,
    output logic [VEC_W-1:0]   win_vector,
    output logic               take_req,
    output logic               preempt
);
    localparam int IDX_W = $clog2(N_IRQ);
    localparam logic [N_IRQ-1:0] ONE = N_IRQ'(1);

    logic [N_IRQ*PRIO_W-1:0] prio_flat;
    logic [N_IRQ-1:0]        en;
    logic [GRP_W-1:0]        grouping;
    logic [N_IRQ-1:0]        pend, act, cand, take_bit, act_bit;
    logic                    nmi_pend, nmi_q;
    logic                    cand_any, act_any;
    logic [IDX_W-1:0]        cand_idx, act_idx;
    logic [PRIO_W-1:0]       cand_key, act_key, mask;
    logic                    win_nmi, grp_lt, take_fire, done_fire;
    gpa_state_e              state, state_nx;

    gpa_cfg_regs #(.N_IRQ(N_IRQ), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .prio_flat(prio_flat), .en(en), .grouping(grouping)
    );

    assign cand = pend & en;

    gpa_pick #(.N(N_IRQ), .W(PRIO_W), .IDX_W(IDX_W)) u_pick_pend (
        .vld(cand), .key_flat(prio_flat), .any(cand_any), .idx(cand_idx), .key_min(cand_key)
    );

    gpa_pick #(.N(N_IRQ), .W(PRIO_W), .IDX_W(IDX_W)) u_pick_act (
        .vld(act), .key_flat(prio_flat), .any(act_any), .idx(act_idx), .key_min(act_key)
    );

    assign win_nmi   = nmi_pend;
    assign mask      = grp_mask(grouping);
    assign grp_lt    = act_any && ((cand_key & mask) < (act_key & mask));
    assign done_fire = handler_done && (state != ST_IDLE);
    assign take_fire = take_ack && take_req && !done_fire;
    assign take_bit  = (take_fire && !win_nmi) ? (ONE << cand_idx) : '0;
    assign act_bit   = ONE << act_idx;

    // Pending and active bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= '0;
            act      <= '0;
            nmi_pend <= 1'b0;
            nmi_q    <= 1'b0;
        end else begin
            nmi_q    <= nmi_i;
            nmi_pend <= (nmi_pend || (nmi_i && !nmi_q)) && !(take_fire && win_nmi);
            pend     <= (pend | (irq_i & en)) & ~take_bit;
            if (done_fire && state != ST_NMI) begin
                act <= act & ~act_bit;
            end else begin
                act <= act | take_bit;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_fire) state_nx = win_nmi ? ST_NMI : ST_HANDLER;
            end
            ST_HANDLER: begin
                if (done_fire)                 state_nx = (|(act & ~act_bit)) ? ST_HANDLER : ST_IDLE;
                else if (take_fire && win_nmi) state_nx = ST_NMI;
            end
            ST_NMI: begin
                if (done_fire) state_nx = (|act) ? ST_HANDLER : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        win_valid  = win_nmi || cand_any;
        win_vector = win_nmi ? VEC_W'(NMI_VEC) : VEC_W'(VEC_BASE) + VEC_W'(cand_idx);
        take_req   = 1'b0;
        preempt    = 1'b0;
        unique case (state)
            ST_IDLE:    take_req = win_valid;
            ST_HANDLER: begin
                preempt  = win_nmi || (cand_any && grp_lt);
                take_req = preempt;
            end
            ST_NMI:     take_req = 1'b0;
            default:    take_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpa_arbiter_chk.sv
module gpa_arbiter_chk
    import gpa_pkg::*;
#(
    parameter int N_IRQ    = 35,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 16,
    parameter int NMI_VEC  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take_ack,
    input logic             handler_done,
    input logic             win_valid,
    input logic [VEC_W-1:0] win_vector,
    input logic             take_req,
    input logic             preempt,
    input gpa_state_e       state
);
    // R1
    idle_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !preempt);

    // R1
    no_take_without_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> !take_req);

    // R4
    vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_vector == VEC_W'(NMI_VEC)) ||
                      (win_vector >= VEC_W'(VEC_BASE) && win_vector < VEC_W'(VEC_BASE + N_IRQ)));

    // R5
    taken_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ack && take_req && !handler_done) |=> !(win_valid && win_vector == $past(win_vector)));

    // R6
    preempt_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |-> (state == ST_HANDLER) && win_valid);

    // R8
    nmi_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NMI) |-> !take_req);

    // R9
    nmi_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NMI && handler_done) |=> (state != ST_NMI));

    // R10
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_ack && !handler_done) |=> $stable(state));
endmodule

bind gpa_arbiter gpa_arbiter_chk #(
    .N_IRQ(N_IRQ), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .NMI_VEC(NMI_VEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .take_ack(take_ack), .handler_done(handler_done),
    .win_valid(win_valid), .win_vector(win_vector), .take_req(take_req),
    .preempt(preempt), .state(state)
);

// File: tb/test_gpa_arbiter.sv
module test_gpa_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [34:0] irq_i = '0;
    logic        nmi_i = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_sel = '0;
    logic [5:0]  cfg_wdata = '0;
    logic        take_ack = 1'b0;
    logic        handler_done = 1'b0;
    logic        win_valid, take_req, preempt;
    logic [7:0]  win_vector;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpa_arbiter i_gpa_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .take_ack(take_ack), .handler_done(handler_done),
        .win_valid(win_valid), .win_vector(win_vector),
        .take_req(take_req), .preempt(preempt)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [5:0] sel, input logic [5:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_irq(input logic [34:0] lines);
        irq_i = lines;
        cyc();
        irq_i = '0;
    endtask

    task automatic ack();
        take_ack = 1'b1;
        cyc();
        take_ack = 1'b0;
    endtask

    task automatic done();
        handler_done = 1'b1;
        cyc();
        handler_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 win_valid", int'(win_valid), 0);
        chk("R1 take_req", int'(take_req), 0);
        chk("R1 preempt", int'(preempt), 0);
    endtask

    task automatic t_pend_enable();
        pulse_irq(35'(1) << 5);
        chk("R3 disabled line ignored", int'(win_valid), 0);
        cfg_write(6'd5, 6'h24);
        chk("R3 enable alone pends nothing", int'(win_valid), 0);
        pulse_irq(35'(1) << 5);
        chk("R3 enabled line pends", int'(win_valid), 1);
        chk("R4 vector 16+5", int'(win_vector), 21);
        chk("R5 idle take_req", int'(take_req), 1);
        cfg_write(6'd5, 6'h04);
        chk("R3 hidden while disabled", int'(win_valid), 0);
        cfg_write(6'd5, 6'h24);
        chk("R3 held and re-presented", int'(win_vector), 21);
        chk("R2 enable visible next cycle", int'(win_valid), 1);
        ack();
        chk("R5 pending cleared on accept", int'(win_valid), 0);
        chk("R5 take_req drops", int'(take_req), 0);
        done();
        chk("R9 back to idle", int'(preempt), 0);
    endtask

    task automatic t_order();
        cfg_write(6'd3, 6'h26);
        cfg_write(6'd10, 6'h22);
        cfg_write(6'd20, 6'h22);
        pulse_irq((35'(1) << 3) | (35'(1) << 10) | (35'(1) << 20));
        chk("R4 tie goes to lower index", int'(win_vector), 26);
        cfg_write(6'd10, 6'h29);
        chk("R2 priority change next cycle", int'(win_vector), 36);
        ack();
        chk("R6 equal-or-lower group no preempt", int'(preempt), 0);
        chk("R6 no take while busy", int'(take_req), 0);
        chk("R4 next winner", int'(win_vector), 19);
        ack();
        chk("R10 ack ignored keeps winner", int'(win_vector), 19);
        chk("R10 ack ignored keeps pending", int'(win_valid), 1);
        done();
        chk("R7 chained take after done", int'(take_req), 1);
        chk("R7 chained take not preempt", int'(preempt), 0);
        ack();
        done();
        chk("R4 last winner", int'(win_vector), 26);
        ack();
        done();
        chk("R5 all served", int'(win_valid), 0);
    endtask

    task automatic t_grouping();
        cfg_write(6'h3F, 6'd4);
        cfg_write(6'd0, 6'h22);
        cfg_write(6'd1, 6'h21);
        cfg_write(6'd7, 6'h28);
        pulse_irq(35'(1) << 7);
        ack();
        pulse_irq(35'(1) << 0);
        chk("R6 lower group preempts", int'(preempt), 1);
        chk("R6 preempt vector", int'(win_vector), 16);
        ack();
        pulse_irq(35'(1) << 1);
        chk("R7 same group no preempt", int'(preempt), 0);
        chk("R7 same group no take", int'(take_req), 0);
        chk("R7 waiting vector", int'(win_vector), 17);
        done();
        chk("R9 retire innermost then preempt outer", int'(preempt), 1);
        ack();
        done();
        chk("R9 outer still running", int'(take_req), 0);
        done();
        chk("R9 idle after last", int'(win_valid), 0);
        cfg_write(6'h3F, 6'd7);
        pulse_irq(35'(1) << 7);
        ack();
        pulse_irq(35'(1) << 0);
        chk("R6 grouping 7 never preempts", int'(preempt), 0);
        cfg_write(6'h3F, 6'd1);
        chk("R6 grouping 1 acts as 2", int'(preempt), 1);
        ack();
        done();
        done();
        chk("R9 idle after grouping test", int'(take_req), 0);
    endtask

    task automatic t_nmi();
        cfg_write(6'd4, 6'h20);
        cfg_write(6'd6, 6'h20);
        pulse_irq(35'(1) << 4);
        ack();
        pulse_irq(35'(1) << 6);
        chk("R7 equal priority waits", int'(take_req), 0);
        nmi_i = 1'b1;
        cyc();
        nmi_i = 1'b0;
        chk("R8 nmi vector", int'(win_vector), 2);
        chk("R8 nmi preempts", int'(preempt), 1);
        ack();
        chk("R8 no take during nmi", int'(take_req), 0);
        chk("R8 peripheral still waiting", int'(win_vector), 22);
        done();
        chk("R9 back to peripheral level", int'(take_req), 0);
        done();
        chk("R7 chained after both end", int'(take_req), 1);
        chk("R7 chained vector", int'(win_vector), 22);
        ack();
        done();
        chk("R5 nothing left", int'(win_valid), 0);
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_pend_enable();
        t_order();
        t_grouping();
        t_nmi();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule